// File: doc/BRIEF.md
# Byte-Wide SPI Flash Command Engine with Shared Ring Buffer

This block lets a host CPU issue one command at a time to a serial flash device through a small bank of byte-wide registers. Software first writes the command opcode and a packed byte-count register. It then pushes the outgoing data bytes through a single data port into an 8-entry ring buffer and sets a start bit. The engine drives chip select low and shifts out the opcode. It then shifts out as many ring bytes as the transmit and receive counts add up to. Each byte captured from the flash during those slots is written back into the ring slot it was taken from.

The ring buffer is never cleared. Software can see its access pointer and can reset it. After a command completes, software resets the pointer and reads past the transmit bytes. The bytes that follow are the response. The serial clock runs in mode 0, most significant bit first. Its rate is a 2-bit field that divides the system clock. The command sequencer is a five-state machine:

- IDLE: chip select high. A start request goes to LOW.
- LOW: serial clock low. A divider tick goes to HIGH, and the input pin is sampled at that transition.
- HIGH: serial clock high. A tick goes back to LOW while bits of the byte remain. After the eighth bit it goes to NEXT.
- NEXT: one cycle. It loads the next ring byte and goes to LOW, or goes to GAP when no bytes remain.
- GAP: chip select high for one full serial clock period, then back to IDLE.

Top module: `spi_eng`

## Requirements
- R1: After reset, registers 0x0, 0x1, 0x2 and 0xD all read 0x00, chip select is high and the serial clock is low.
- R2: Register 0x0 holds the opcode. Register 0x1 holds the receive count in bits 7:4 and the transmit count in bits 3:0. Both registers read back exactly the last value accepted.
- R3: While idle, a write to the data port at 0xC stores the byte at the current pointer. A read of 0xC returns the byte at the current pointer. Either access advances the pointer by one modulo 8. The pointer reads in bits 2:0 of 0xD.
- R4: A write to 0x2 with bit 4 set forces the pointer to 0.
- R5: A write to 0x2 with bit 0 set while idle starts a command. Bit 0 of 0x2 reads 1 from then until the command, including its closing chip-select gap, is over, and 0 afterwards.
- R6: During a command, chip select is low for the whole frame. The frame carries the opcode and then (tx + rx) bytes, each taken from the ring slot at the pointer when its turn comes. Every byte goes out MSB first in mode 0: the output changes while the clock is low and is sampled on the rising edge.
- R7: The byte received during the opcode is discarded. Every later received byte is stored in the ring slot its transmit byte came from, and the pointer then advances. The pointer ends at (start + tx + rx) mod 8.
- R8: Bits 5:4 of 0xD hold the rate code r and read back as written. The serial clock period within a byte is 2*(r+1) system clock cycles.
- R9: The serial clock is low whenever chip select is high. Chip select stays high for at least one serial clock period before the busy bit clears.
- R10: While a command runs, writes to 0x0, 0x1 and 0xC change nothing, and reads of 0xC do not move the pointer.
- R11: Ring slots not reached by a command keep their previous contents, and a pointer reset leaves all contents intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, twice the fastest serial clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register byte address |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register, valid in the cycle of the strobe |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash device |
| spi_miso | input | 1 | Serial data from the flash device |

## Verification
The properties assume that the host raises at most one strobe per cycle. They also assume that the host does not rewrite the rate field in the middle of a command, and that the flash changes its output only after falling clock edges. The bench meets these assumptions by construction. Its access tasks issue a single strobe and release it one cycle later. The rate is always programmed before the opcode. The serial device model updates its output pin only on falling clock edges and when chip select falls. Random commands stay within five transmit and eight receive bytes. Directed cases cover the empty command, ring wrap past eight bytes, and register accesses made while the engine is busy.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_NEXT,
        ST_GAP
    } eng_state_t;

    localparam logic [3:0] ADR_OPC  = 4'h0;
    localparam logic [3:0] ADR_CNT  = 4'h1;
    localparam logic [3:0] ADR_CTL  = 4'h2;
    localparam logic [3:0] ADR_DATA = 4'hC;
    localparam logic [3:0] ADR_STAT = 4'hD;

endpackage

// File: rtl/spi_eng_tick.sv
module spi_eng_tick #(
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              clr,
    input  logic [RATE_W-1:0] div,
    output logic              tick
);
    logic [RATE_W-1:0] cnt_q;

    assign tick = en && !clr && (cnt_q >= div);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || !en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + RATE_W'(1);
        end
    end
endmodule

// File: rtl/spi_eng_ring.sv
module spi_eng_ring #(
    parameter int DEPTH = 8,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_clr,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             adv,
    output logic [7:0]       rd_data,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] ptr_q;

    assign ptr     = ptr_q;
    assign rd_data = mem[ptr_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[ptr_q] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_clr) begin
            ptr_q <= '0;
        end else if (wr_en || adv) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
        end
    end
endmodule

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
    import spi_eng_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] opcode,
    input  logic [7:0] counts,
    input  logic       tick,
    input  logic [7:0] ring_rd,
    input  logic       miso,
    output logic       busy,
    output logic       tick_en,
    output logic       tick_clr,
    output logic       sck,
    output logic       cs_n,
    output logic       mosi,
    output logic       rx_wr,
    output logic [7:0] rx_data
);
    eng_state_t state_q, state_d;

    logic [7:0] shreg_q;
    logic [7:0] rxsh_q;
    logic [2:0] bitcnt_q;
    logic [4:0] remain_q;
    logic       is_op_q;
    logic       gap_half_q;

    logic byte_end;
    assign byte_end = (state_q == ST_HIGH) && tick && (bitcnt_q == 3'd0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go) state_d = ST_LOW;
            ST_LOW:  if (tick) state_d = ST_HIGH;
            ST_HIGH: if (tick) state_d = (bitcnt_q == 3'd0) ? ST_NEXT : ST_LOW;
            ST_NEXT: state_d = (remain_q == 5'd0) ? ST_GAP : ST_LOW;
            ST_GAP:  if (tick && gap_half_q) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q    <= '0;
            rxsh_q     <= '0;
            bitcnt_q   <= '0;
            remain_q   <= '0;
            is_op_q    <= 1'b0;
            gap_half_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        shreg_q    <= opcode;
                        bitcnt_q   <= 3'd7;
                        remain_q   <= {1'b0, counts[3:0]} + {1'b0, counts[7:4]};
                        is_op_q    <= 1'b1;
                        gap_half_q <= 1'b0;
                    end
                end
                ST_LOW: begin
                    if (tick) rxsh_q <= {rxsh_q[6:0], miso};
                end
                ST_HIGH: begin
                    if (tick) begin
                        if (bitcnt_q != 3'd0) begin
                            shreg_q  <= {shreg_q[6:0], 1'b0};
                            bitcnt_q <= bitcnt_q - 3'd1;
                        end else begin
                            is_op_q <= 1'b0;
                        end
                    end
                end
                ST_NEXT: begin
                    if (remain_q != 5'd0) begin
                        shreg_q  <= ring_rd;
                        bitcnt_q <= 3'd7;
                        remain_q <= remain_q - 5'd1;
                    end
                end
                ST_GAP: begin
                    if (tick) gap_half_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy     = (state_q != ST_IDLE);
        cs_n     = (state_q == ST_IDLE) || (state_q == ST_GAP);
        sck      = (state_q == ST_HIGH);
        mosi     = cs_n ? 1'b0 : shreg_q[7];
        tick_en  = (state_q == ST_LOW) || (state_q == ST_HIGH) || (state_q == ST_GAP);
        tick_clr = (state_q == ST_NEXT);
        rx_wr    = byte_end && !is_op_q;
        rx_data  = rxsh_q;
    end
endmodule

// File: rtl/spi_eng.sv
module spi_eng
    import spi_eng_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int RATE_W = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       spi_sck,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [7:0]        op_q;
    logic [7:0]        cnt_q;
    logic [RATE_W-1:0] rate_q;

    logic             busy, go, ptr_clr;
    logic             tick, tick_en, tick_clr;
    logic             eng_wr;
    logic [7:0]       eng_data;
    logic [7:0]       ring_rd;
    logic [PTR_W-1:0] ptr;
    logic             host_dat_wr, host_dat_rd;
    logic             ring_wr;
    logic [7:0]       ring_wdata;
    logic [2:0]       ptr_view;

    assign go          = reg_wr && (reg_addr == ADR_CTL) && reg_wdata[0] && !busy;
    assign ptr_clr     = reg_wr && (reg_addr == ADR_CTL) && reg_wdata[4];
    assign host_dat_wr = reg_wr && (reg_addr == ADR_DATA) && !busy;
    assign host_dat_rd = reg_rd && (reg_addr == ADR_DATA) && !busy;
    assign ring_wr     = host_dat_wr || eng_wr;
    assign ring_wdata  = eng_wr ? eng_data : reg_wdata;
    assign ptr_view    = 3'(ptr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= '0;
            cnt_q  <= '0;
            rate_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADR_OPC && !busy)  op_q   <= reg_wdata;
            if (reg_addr == ADR_CNT && !busy)  cnt_q  <= reg_wdata;
            if (reg_addr == ADR_STAT)          rate_q <= reg_wdata[4 +: RATE_W];
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADR_OPC:  reg_rdata = op_q;
            ADR_CNT:  reg_rdata = cnt_q;
            ADR_CTL:  reg_rdata = {7'd0, busy};
            ADR_DATA: reg_rdata = ring_rd;
            ADR_STAT: reg_rdata = {2'd0, 2'(rate_q), 1'b0, ptr_view};
            default:  reg_rdata = 8'd0;
        endcase
    end

    spi_eng_tick #(.RATE_W(RATE_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tick_en),
        .clr   (tick_clr),
        .div   (rate_q),
        .tick  (tick)
    );

    spi_eng_ring #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .ptr_clr (ptr_clr),
        .wr_en   (ring_wr),
        .wr_data (ring_wdata),
        .adv     (host_dat_rd),
        .rd_data (ring_rd),
        .ptr     (ptr)
    );

    spi_eng_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .opcode   (op_q),
        .counts   (cnt_q),
        .tick     (tick),
        .ring_rd  (ring_rd),
        .miso     (spi_miso),
        .busy     (busy),
        .tick_en  (tick_en),
        .tick_clr (tick_clr),
        .sck      (spi_sck),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi),
        .rx_wr    (eng_wr),
        .rx_data  (eng_data)
    );
endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk #(
    parameter int PTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             spi_cs_n,
    input logic             spi_sck,
    input logic             busy,
    input logic             go,
    input logic             ptr_clr,
    input logic [PTR_W-1:0] ptr,
    input logic [7:0]       op_q,
    input logic [7:0]       cnt_q
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_SCK_PARKED: assert property (@(posedge clk) disable iff (!rst_n) spi_cs_n |-> !spi_sck); // R9
    AST_CS_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> spi_cs_n); // R5
    AST_START_ON_GO: assert property (@(posedge clk) disable iff (!rst_n || !past_ok) $rose(busy) |-> $past(go)); // R5
    AST_REGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n || !past_ok) (busy && $past(busy)) |-> ($stable(op_q) && $stable(cnt_q))); // R10
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n || !past_ok) (ptr != $past(ptr)) |-> ($past(ptr_clr) ? (ptr == '0) : (ptr == $past(ptr) + PTR_W'(1)))); // R3
    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) ptr_clr |=> (ptr == '0)); // R4
endmodule

bind spi_eng spi_eng_chk #(.PTR_W($clog2(DEPTH))) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_cs_n (spi_cs_n),
    .spi_sck  (spi_sck),
    .busy     (busy),
    .go       (go),
    .ptr_clr  (ptr_clr),
    .ptr      (ptr),
    .op_q     (op_q),
    .cnt_q    (cnt_q)
);

// File: tb/sim_spi_eng.sv
module sim_spi_eng;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       sck, cs_n, mosi;
    logic       miso = 1'b0;

    always #4 clk = ~clk;

    spi_eng u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_rd(rd),
        .reg_wdata(wdata), .reg_rdata(rdata), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] mdl [8];
    int         mptr = 0;
    logic [7:0] resp [32];
    logic [7:0] cap  [32];
    int         sbit = 0;
    int         capn = 0;
    longint     rise0 = 0, rise1 = 0, cs_rise = 0;

    task automatic chk_eq(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    // serial device model: drives on falling edges, captures on rising edges
    initial forever begin
        @(negedge cs_n);
        sbit = 0; capn = 0;
        miso = resp[0][7];
    end
    initial forever begin
        @(negedge sck);
        if (!cs_n) begin
            sbit++;
            miso = resp[(sbit / 8) % 32][7 - (sbit % 8)];
        end
    end
    initial forever begin
        @(posedge sck);
        cap[(capn / 8) % 32][7 - (capn % 8)] = mosi;
        if (capn == 0) rise0 = $time;
        if (capn == 1) rise1 = $time;
        capn++;
    end
    initial forever begin
        @(posedge cs_n);
        cs_rise = $time;
    end

    task automatic run_cmd(input logic [7:0] op, input int tx, input int rx,
                           input int rate, input bit poke);
        logic [7:0] v;
        logic [7:0] d;
        logic [7:0] expb [32];
        int n;
        longint tdone;
        wr_reg(4'hD, 8'(rate << 4));
        for (int i = 0; i < 32; i++) resp[i] = 8'($urandom);
        wr_reg(4'h0, op);
        wr_reg(4'h1, {4'(rx), 4'(tx)});
        wr_reg(4'h2, 8'h10); mptr = 0;
        for (int i = 0; i < tx; i++) begin
            d = 8'($urandom);
            wr_reg(4'hC, d);
            mdl[mptr] = d; mptr = (mptr + 1) % 8;
        end
        rd_reg(4'hD, v);
        chk_eq("R3 ptr after fill", int'(v[2:0]), tx % 8);
        wr_reg(4'h2, 8'h10); mptr = 0;
        // expected frame and ring after the command
        expb[0] = op;
        for (int k = 0; k < tx + rx; k++) begin
            expb[k + 1] = mdl[k % 8];
            mdl[k % 8] = resp[k + 1];
        end
        wr_reg(4'h2, 8'h01);
        if (poke) begin
            wr_reg(4'h0, 8'hEE);
            wr_reg(4'h1, 8'h77);
            wr_reg(4'hC, 8'h55);
            rd_reg(4'hC, v);
            rd_reg(4'h2, v);
            chk_eq("R5 busy bit while running", int'(v[0]), 1);
        end
        n = 0;
        do begin
            rd_reg(4'h2, v);
            n++;
        end while (v[0] && n < 5000);
        tdone = $time;
        chk_eq("R5 busy bit clears", int'(v[0]), 0);
        chk_eq("R6 bits in frame", capn, 8 * (1 + tx + rx));
        for (int k = 0; k < 1 + tx + rx; k++)
            chk_eq("R6 mosi byte", int'(cap[k]), int'(expb[k]));
        chk_eq("R8 sck period", int'((rise1 - rise0) / 8), 2 * (rate + 1));
        chk_eq("R9 cs gap before idle", int'(((tdone - cs_rise) / 8) >= 2 * (rate + 1)), 1);
        rd_reg(4'hD, v);
        chk_eq("R7 final ptr", int'(v[2:0]), (tx + rx) % 8);
        chk_eq("R8 rate readback", int'(v[5:4]), rate);
        rd_reg(4'h0, v);
        chk_eq("R2 R10 opcode readback", int'(v), int'(op));
        rd_reg(4'h1, v);
        chk_eq("R2 R10 count readback", int'(v), int'({4'(rx), 4'(tx)}));
        wr_reg(4'h2, 8'h10);
        for (int i = 0; i < 8; i++) begin
            rd_reg(4'hC, v);
            chk_eq("R7 R11 ring slot", int'(v), int'(mdl[i]));
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 190000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd4242));
        for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
        for (int i = 0; i < 32; i++) resp[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_reg(4'h0, v); chk_eq("R1 opcode reset", int'(v), 0);
        rd_reg(4'h1, v); chk_eq("R1 count reset", int'(v), 0);
        rd_reg(4'h2, v); chk_eq("R1 control reset", int'(v), 0);
        rd_reg(4'hD, v); chk_eq("R1 status reset", int'(v), 0);
        chk_eq("R1 cs high", int'(cs_n), 1);
        chk_eq("R1 sck low", int'(sck), 0);

        // R3 wrap of the data port: nine writes land at 0..7 then 0
        for (int i = 0; i < 9; i++) begin
            wr_reg(4'hC, 8'(8'hA0 + i));
            mdl[i % 8] = 8'(8'hA0 + i);
        end
        rd_reg(4'hD, v); chk_eq("R3 ptr wrap", int'(v[2:0]), 1);
        // R4 pointer reset
        wr_reg(4'h2, 8'h10);
        rd_reg(4'hD, v); chk_eq("R4 ptr cleared", int'(v[2:0]), 0);
        for (int i = 0; i < 8; i++) begin
            rd_reg(4'hC, v); chk_eq("R3 R11 readback", int'(v), int'(mdl[i]));
        end
        rd_reg(4'hD, v); chk_eq("R3 ptr after 8 reads", int'(v[2:0]), 0);

        // directed commands
        run_cmd(8'h05, 0, 0, 0, 1'b0);  // opcode only, R6
        run_cmd(8'h9F, 1, 1, 1, 1'b0);  // untouched slots keep data, R11
        run_cmd(8'h0B, 5, 8, 2, 1'b0);  // ring wraps, R7
        run_cmd(8'h03, 2, 3, 3, 1'b1);  // accesses during busy ignored, R10

        // random commands
        for (int t = 0; t < 12; t++)
            run_cmd(8'($urandom), int'($urandom % 6), int'($urandom % 9),
                    int'($urandom % 4), 1'b0);

        finish_run();
    end
endmodule